// File: doc/BRIEF.md
# Framed Serial Line Transmitter with Stuff Bits

This block drives a bit-serial line, one bit per clock, where every clock cycle is one bit period. An external frame pulse marks each frame start. When its rising edge is sampled, the block sends a fixed 14-bit sync pattern, most significant bit first. It then opens a payload window of either a short or a long length. During that window it raises a data-request strobe, and the payload input passes straight to the line with no change to the data. After the payload it holds the line at 0 until the next frame pulse.

The application controls frame timing. It keeps a nominal rate by placing the next pulse so that the sync pattern follows the last payload bit with no gap. It can also delay the pulse by four bit periods, which puts four zero stuff bits on the line before the next sync pattern. A pulse at any other position raises a one-cycle error flag, and framing restarts from that pulse.

Top module: `serial_framer_tx`

## Requirements
- R1: In the 14 cycles that follow the cycle in which a rising edge of `frame_pulse` is sampled, `line_out` carries `SYNC_WORD` (14 bits), bit 13 first and bit 0 last.
- R2: The payload window lasts `PAY_SHORT` cycles (default 4,688) when `len_sel` = 0 and `PAY_LONG` cycles (default 6,992) when `len_sel` = 1. `len_sel` is sampled in the same cycle as the frame pulse edge. A short frame is therefore 4,702 bits long.
- R3: `data_req` is 1 in every payload cycle and 0 in every sync, stuff and idle cycle. No payload is taken during the sync pattern.
- R4: In a cycle where `data_req` is 1, `line_out` equals `pay_bit` of that same cycle, for any data pattern.
- R5: After the last payload bit and until the next sync pattern, `line_out` is 0. A pulse edge sampled in the fourth cycle after the last payload bit starts the next sync with no error, so exactly four 0 stuff bits are sent.
- R6: A pulse edge sampled in the last payload cycle starts the next sync in the following cycle, with no gap and no error.
- R7: A pulse edge sampled at any other point of a running frame (during sync, before the last payload bit, or 1, 2, 3, 5 or more cycles after it) sets `frame_err` to 1 for exactly the first sync cycle of the new frame. Framing restarts from that edge.
- R8: After reset and before the first pulse edge, `line_out`, `data_req` and `frame_err` are 0.
- R9: Only a low-to-high change of `frame_pulse` starts a frame. Holding the pulse high for several cycles does not start it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Frame start marker, edge-detected on `clk` |
| len_sel | input | 1 | Payload length select (0 short, 1 long), sampled at the pulse edge |
| pay_bit | input | 1 | Payload data bit, used while `data_req` is 1 |
| line_out | output | 1 | Serial line bit |
| data_req | output | 1 | High in cycles that consume `pay_bit` |
| frame_err | output | 1 | One-cycle flag for a frame pulse at a wrong position |

## Verification
The hardest case to reach is a pulse edge near the end of the payload. Only offsets 0 and 4 after the last payload bit are legal, and the neighbouring offsets 1, 2, 3 and 5 must all be flagged. Reaching every one of these needs precise cycle counting over a long frame. The bench therefore builds the design with short payload lengths and sweeps the gap between successive pulses over every value, from two cycles up to past the stuff window, for both length selections. A reference position counter in the bench predicts every output bit and every error flag. A held-high pulse case covers edge detection.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SYNC = 2'd1,
      ST_PAY  = 2'd2,
      ST_GAP  = 2'd3
   } ftx_state_e;

   function automatic int unsigned ftx_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ftx_edge_detect.sv
module ftx_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic rise
);

   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= 1'b0;
      end else begin
         level_q <= level_in;
      end
   end

   assign rise = level_in & ~level_q;

endmodule

// File: rtl/ftx_seq.sv
module ftx_seq
   import ftx_pkg::*;
#(
   parameter int unsigned SYNC_LEN  = 14,
   parameter int unsigned PAY_SHORT = 4688,
   parameter int unsigned PAY_LONG  = 6992,
   parameter int unsigned STUFF_LEN = 4,
   localparam int unsigned MAXC     = ftx_max(ftx_max(PAY_SHORT, PAY_LONG), SYNC_LEN),
   localparam int unsigned CW       = $clog2(MAXC + 1),
   localparam int unsigned GW       = $clog2(STUFF_LEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rise,
   input  logic            len_sel,
   output ftx_state_e      state,
   output logic [CW-1:0]   idx,
   output logic            err
);

   localparam logic [CW-1:0] SYNC_LAST  = CW'(SYNC_LEN - 1);
   localparam logic [CW-1:0] SHORT_LAST = CW'(PAY_SHORT - 1);
   localparam logic [CW-1:0] LONG_LAST  = CW'(PAY_LONG - 1);
   localparam logic [GW-1:0] GAP_OK     = GW'(STUFF_LEN - 1);
   localparam logic [GW-1:0] GAP_SAT    = GW'(STUFF_LEN);

   ftx_state_e      state_q;
   logic [CW-1:0]   cnt_q;
   logic [GW-1:0]   gap_q;
   logic            long_q;
   logic            err_q;
   logic [CW-1:0]   pay_last;
   logic            at_pay_end;
   logic            legal_rise;

   assign pay_last   = long_q ? LONG_LAST : SHORT_LAST;
   assign at_pay_end = (state_q == ST_PAY) && (cnt_q == pay_last);

   always_comb begin
      unique case (state_q)
         ST_IDLE: legal_rise = 1'b1;
         ST_PAY:  legal_rise = at_pay_end;
         ST_GAP:  legal_rise = (gap_q == GAP_OK);
         default: legal_rise = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         gap_q   <= '0;
         long_q  <= 1'b0;
         err_q   <= 1'b0;
      end else if (rise) begin
         state_q <= ST_SYNC;
         cnt_q   <= '0;
         gap_q   <= '0;
         long_q  <= len_sel;
         err_q   <= ~legal_rise;
      end else begin
         err_q <= 1'b0;
         unique case (state_q)
            ST_SYNC: begin
               if (cnt_q == SYNC_LAST) begin
                  state_q <= ST_PAY;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_PAY: begin
               if (at_pay_end) begin
                  state_q <= ST_GAP;
                  gap_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (gap_q != GAP_SAT) begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign state = state_q;
   assign idx   = cnt_q;
   assign err   = err_q;

endmodule

// File: rtl/ftx_sync_shreg.sv
module ftx_sync_shreg #(
   parameter int unsigned     SYNC_LEN  = 14,
   parameter logic [SYNC_LEN-1:0] SYNC_WORD = 14'h2C8D,
   parameter int unsigned     CW        = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_sync,
   input  logic [CW-1:0] idx,
   output logic          sync_bit
);

   logic [SYNC_LEN-1:0] sr_q;
   logic                first;

   assign first = (idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (in_sync) begin
         sr_q <= first ? (SYNC_WORD << 1) : (sr_q << 1);
      end
   end

   assign sync_bit = first ? SYNC_WORD[SYNC_LEN-1] : sr_q[SYNC_LEN-1];

endmodule

// File: rtl/ftx_line_mux.sv
module ftx_line_mux
   import ftx_pkg::*;
(
   input  ftx_state_e state,
   input  logic       sync_bit,
   input  logic       pay_bit,
   output logic       line_out,
   output logic       data_req
);

   always_comb begin
      line_out = 1'b0;
      data_req = 1'b0;
      unique case (state)
         ST_SYNC: line_out = sync_bit;
         ST_PAY: begin
            line_out = pay_bit;
            data_req = 1'b1;
         end
         default: line_out = 1'b0;
      endcase
   end

endmodule

// File: rtl/serial_framer_tx.sv
module serial_framer_tx
   import ftx_pkg::*;
#(
   parameter int unsigned         SYNC_LEN  = 14,
   parameter logic [SYNC_LEN-1:0] SYNC_WORD = 14'h2C8D,
   parameter int unsigned         PAY_SHORT = 4688,
   parameter int unsigned         PAY_LONG  = 6992,
   parameter int unsigned         STUFF_LEN = 4,
   parameter int unsigned         SYNC_IMPL = 0,
   localparam int unsigned        MAXC      = ftx_max(ftx_max(PAY_SHORT, PAY_LONG), SYNC_LEN),
   localparam int unsigned        CW        = $clog2(MAXC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_pulse,
   input  logic len_sel,
   input  logic pay_bit,
   output logic line_out,
   output logic data_req,
   output logic frame_err
);

   if (SYNC_LEN < 2) begin : g_bad_sync
      $error("SYNC_LEN must be at least 2");
   end
   if (PAY_SHORT < 2 || PAY_LONG < 2) begin : g_bad_pay
      $error("payload lengths must be at least 2");
   end
   if (STUFF_LEN < 1) begin : g_bad_stuff
      $error("STUFF_LEN must be at least 1");
   end
   if (SYNC_IMPL > 1) begin : g_bad_impl
      $error("SYNC_IMPL must be 0 or 1");
   end

   logic          rise;
   ftx_state_e    state;
   logic [CW-1:0] idx;
   logic          sync_bit;

   ftx_edge_detect u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (frame_pulse),
      .rise     (rise)
   );

   ftx_seq #(
      .SYNC_LEN  (SYNC_LEN),
      .PAY_SHORT (PAY_SHORT),
      .PAY_LONG  (PAY_LONG),
      .STUFF_LEN (STUFF_LEN)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise),
      .len_sel (len_sel),
      .state   (state),
      .idx     (idx),
      .err     (frame_err)
   );

   if (SYNC_IMPL == 0) begin : g_sync_mux
      localparam logic [CW-1:0] TOP = CW'(SYNC_LEN - 1);
      logic [CW-1:0] pick;
      assign pick     = TOP - idx;
      assign sync_bit = SYNC_WORD[pick[$clog2(SYNC_LEN)-1:0]];
   end else begin : g_sync_shreg
      ftx_sync_shreg #(
         .SYNC_LEN  (SYNC_LEN),
         .SYNC_WORD (SYNC_WORD),
         .CW        (CW)
      ) u_shreg (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_sync  (state == ST_SYNC),
         .idx      (idx),
         .sync_bit (sync_bit)
      );
   end

   ftx_line_mux u_mux (
      .state    (state),
      .sync_bit (sync_bit),
      .pay_bit  (pay_bit),
      .line_out (line_out),
      .data_req (data_req)
   );

endmodule

// File: rtl/serial_framer_tx_chk.sv
module serial_framer_tx_chk #(
   parameter int unsigned         SYNC_LEN  = 14,
   parameter logic [SYNC_LEN-1:0] SYNC_WORD = 14'h2C8D
) (
   input logic clk,
   input logic rst_n,
   input logic frame_pulse,
   input logic pay_bit,
   input logic line_out,
   input logic data_req,
   input logic frame_err
);

   localparam int unsigned SW = $clog2(SYNC_LEN + 2);

   logic          fp_q;
   logic          rise_c;
   logic          started;
   logic [SW-1:0] sc;
   logic          in_sync_win;
   logic          exp_sync;

   assign rise_c = frame_pulse & ~fp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fp_q    <= 1'b0;
         started <= 1'b0;
         sc      <= '0;
      end else begin
         fp_q <= frame_pulse;
         if (rise_c) begin
            started <= 1'b1;
            sc      <= SW'(1);
         end else if (sc != '0 && sc != SW'(SYNC_LEN + 1)) begin
            sc <= sc + 1'b1;
         end
      end
   end

   assign in_sync_win = (sc != '0) && (sc <= SW'(SYNC_LEN));

   always_comb begin
      exp_sync = 1'b0;
      for (int i = 0; i < SYNC_LEN; i++) begin
         if (sc == SW'(SYNC_LEN - i)) exp_sync = SYNC_WORD[i];
      end
   end

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (!line_out && !data_req && !frame_err));

   // R3
   sync_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_sync_win |-> !data_req);

   // R1
   sync_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_sync_win |-> (line_out == exp_sync));

   // R4
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_req |-> (line_out == pay_bit));

   // R5
   stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !in_sync_win && !data_req) |-> !line_out);

   // R7
   err_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> $past(rise_c));

   // R7
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

endmodule

bind serial_framer_tx serial_framer_tx_chk #(
   .SYNC_LEN  (SYNC_LEN),
   .SYNC_WORD (SYNC_WORD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_pulse (frame_pulse),
   .pay_bit     (pay_bit),
   .line_out    (line_out),
   .data_req    (data_req),
   .frame_err   (frame_err)
);

// File: tb/serial_framer_tx_tb.sv
module serial_framer_tx_tb;

   localparam int unsigned SL  = 14;
   localparam logic [SL-1:0] SW = 14'h2C8D;
   localparam int unsigned PS  = 20;
   localparam int unsigned PL  = 27;
   localparam int unsigned STF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_pulse = 1'b0;
   logic len_sel = 1'b0;
   logic pay_bit = 1'b0;
   logic line_out, data_req, frame_err;

   always #2 clk = ~clk;

   serial_framer_tx #(
      .SYNC_LEN  (SL),
      .SYNC_WORD (SW),
      .PAY_SHORT (PS),
      .PAY_LONG  (PL),
      .STUFF_LEN (STF),
      .SYNC_IMPL (1)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_pulse (frame_pulse),
      .len_sel     (len_sel),
      .pay_bit     (pay_bit),
      .line_out    (line_out),
      .data_req    (data_req),
      .frame_err   (frame_err)
   );

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;
   int cyc     = 0;

   // reference model state
   int pos     = 0;
   int cur_n   = PS;
   bit fp_prev = 0;
   bit err_exp = 0;
   bit last_bad = 0;
   string phase = "";

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: run did not end, cycle %0d", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s pos=%0d: actual %0b expected %0b", tag, phase, pos, act, exp);
      end
   endtask

   task automatic step(input bit fp, input bit ls);
      bit rise;
      @(negedge clk);
      frame_pulse = fp;
      len_sel     = ls;
      pay_bit     = 1'($urandom);
      #1;
      if (pos == 0) begin
         chk("R8 line", line_out, 1'b0);
         chk("R8 req", data_req, 1'b0);
      end else if (pos <= int'(SL)) begin
         chk("R1 sync", line_out, SW[SL - pos]);
         chk("R3 req-in-sync", data_req, 1'b0);
      end else if (pos <= int'(SL) + cur_n) begin
         chk("R4 data", line_out, pay_bit);
         chk("R3 req-in-payload", data_req, 1'b1);
      end else begin
         chk("R5 stuff", line_out, 1'b0);
         if (pos == int'(SL) + cur_n + 1)
            chk("R2 length", data_req, 1'b0);
         else
            chk("R3 req-after", data_req, 1'b0);
      end
      if (err_exp) chk("R7 err", frame_err, 1'b1);
      else if (pos == 1) chk("R6 noerr", frame_err, 1'b0);
      else chk("R7 quiet", frame_err, 1'b0);
      // advance model across the coming edge
      rise = fp && !fp_prev;
      fp_prev = fp;
      if (rise) begin
         last_bad = (pos != 0) && (pos != int'(SL) + cur_n) && (pos != int'(SL) + cur_n + int'(STF));
         err_exp = last_bad;
         pos = 1;
         cur_n = ls ? int'(PL) : int'(PS);
      end else begin
         err_exp = 0;
         if (pos != 0 && pos < 100000) pos++;
      end
   endtask

   initial begin
      for (int i = 0; i < 4; i++) @(negedge clk);
      rst_n = 1'b1;
      phase = "idle";
      for (int i = 0; i < 10; i++) step(0, 0);

      // sweep every gap between pulse edges, for both lengths (R2, R5, R6, R7)
      for (int ls = 0; ls < 2; ls++) begin
         int n;
         n = (ls == 1) ? int'(PL) : int'(PS);
         step(1, 1'(ls));
         for (int g = 2; g <= int'(SL) + n + int'(STF) + 3; g++) begin
            phase = $sformatf("sweep ls=%0d gap=%0d", ls, g);
            for (int k = 0; k < g - 1; k++) step(0, 1'(ls));
            step(1, 1'(ls));
         end
      end

      // nominal back-to-back and stuffed frames with the long/short mix
      phase = "mix";
      for (int f = 0; f < 6; f++) begin
         for (int k = 0; k < int'(SL) + cur_n - 1 + ((f % 2) ? int'(STF) : 0); k++) step(0, 1'(f % 2));
         step(1, 1'(f % 2));
      end

      // R9: held-high pulse must not restart the frame
      phase = "R9 hold";
      for (int k = 0; k < int'(SL) + cur_n - 1; k++) step(0, 0);
      for (int k = 0; k < 6; k++) step(1, 0);
      for (int k = 0; k < int'(SL) + cur_n + 6; k++) step(0, 0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule